// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models the device-side logic of a byte-wide flash array while an internal program or erase operation is running. It watches write strobes for the unlock-and-command sequences that start an operation. It latches the target address and byte, and it runs the operation's time windows in clock cycles. While the operation is busy, it puts status bits on the read data bus in place of array contents.

Bit 7 reports progress by polarity. Bit 6 flips on every read access. Bit 5 reports that the operation ran past its time limit. Sector protection is a parameter. A protected target gives a short toggling window and leaves every cell unchanged. An external operation timer reports the end of a real program or erase through `op_done`. When no operation is active, reads return the byte stored at the address.

Top module: `flash_status_gen`

## Requirements
- R1: After reset every array byte reads 8'hFF, no operation is active, and `dout` shows the byte at `addr`.
- R2: A write is counted at a rising edge of `we_n` while `ce_n` is low. Program is the data bytes AA, 55, A0 and then the target address and byte, which makes 4 writes. Erase is AA, 55, 80, AA, 55 and then 10 for chip erase or 30 for erase of the sector holding `addr`, which makes 6 writes. A byte that does not fit the sequence returns it to the start. Unlock addresses are don't-care. Status is reported from the clock edge that sees the last write's rising edge.
- R3: While a program is busy, `dout[7]` is the inverse of bit 7 of the byte being programmed. On `op_done` the byte is ANDed into the cell, and later reads return the true stored value.
- R4: While an erase is busy, `dout[7]` is 0. On `op_done` each selected, unprotected sector reads 8'hFF, so bit 7 reads 1.
- R5: Bit 6 is cleared when an operation starts. While the operation is busy, it inverts once for each read access, so the first read shows 1. A read access is a falling edge of `ce_n` or of `oe_n`. Simultaneous falls count as one access. With no access, bit 6 holds.
- R6: While an operation is busy and has not failed, `dout[5:0]` reads 0.
- R7: A sector erase first runs a window of SE_WIN_CYC cycles. During the window bit 6 toggles, bit 7 reads 0 and `op_done` is ignored. The erase proper begins after the window.
- R8: A program aimed at a protected sector is busy for PROT_PGM_CYC cycles with bit 6 toggling. It then returns to reading array data with the cell unchanged, and `op_done` is ignored throughout.
- R9: An erase whose selected sectors are all protected is busy for PROT_ERS_CYC cycles and then returns to read mode with no byte changed. A chip erase clears only the unprotected sectors.
- R10: If a program or erase stays busy for TIMEOUT_CYC cycles without `op_done`, the block fails. In the failed state `dout` = {poll bit, 0, 1, 5'b0}, and it stays there until reset, ignoring `op_done` and commands.
- R11: With no operation active, a read returns the array byte at `addr`. Writes that do not complete a command, and any command written while an operation is busy, change nothing.
- R12: The sector is the top SECT_W bits of `addr`. Bit i of PROT_MASK protects sector i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data byte |
| op_done | input | 1 | Completion pulse from the operation timer |
| dout | output | 8 | Read data: array byte or status byte |

## Verification
The bench goes after the polarity of bit 7 for both values of the programmed bit. A design that forwarded rather than inverted the bit would read the same value whether busy or done. It counts bit 6 flips across read accesses made by output enable, by chip enable, and by both falling together. A design that counted each edge separately would lose the alternation. It sends `op_done` into the sector-erase window and into both protected windows, where a design that obeyed it early would alter cells or end the status too soon. It holds a program past the time limit and checks that the failed status stays put until reset. It also checks that commands written during a busy operation leave the array untouched.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;
  localparam logic [7:0] OPC_PGM   = 8'hA0;
  localparam logic [7:0] OPC_ERS   = 8'h80;
  localparam logic [7:0] OPC_CHIP  = 8'h10;
  localparam logic [7:0] OPC_SECT  = 8'h30;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_PGM,
    CMD_CHIP_ERS,
    CMD_SECT_ERS
  } cmd_e;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SE_WIN,
    OP_PGM,
    OP_ERS,
    OP_PROT,
    OP_FAIL
  } op_state_e;

  // Polarity-encoded progress bit: erase shows 0, program shows inverted data.
  function automatic logic f_poll_bit(input logic is_erase, input logic d7);
    return is_erase ? 1'b0 : ~d7;
  endfunction

  // Status byte layout: {poll, toggle, timeout, 5'b0}.
  function automatic logic [7:0] f_status_byte(input logic p7, input logic t6,
                                               input logic f5);
    return {p7, t6, f5, 5'b00000};
  endfunction

endpackage

// File: rtl/fsg_cmd_seq.sv
module fsg_cmd_seq
  import flash_status_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              enable,
  output logic              cmd_valid,
  output cmd_e              cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic              we_rise
);

  typedef enum logic [2:0] {
    SQ_W1, SQ_W2, SQ_W3, SQ_PDATA, SQ_W4, SQ_W5, SQ_W6
  } seq_e;

  seq_e seq_q, seq_d;
  logic we_q;

  assign we_rise  = !ce_n && we_n && !we_q;
  assign cmd_addr = addr;
  assign cmd_data = din;

  always_comb begin
    seq_d     = seq_q;
    cmd_valid = 1'b0;
    cmd_kind  = CMD_NONE;
    if (!enable) begin
      seq_d = SQ_W1;
    end else if (we_rise) begin
      seq_d = SQ_W1;
      case (seq_q)
        SQ_W1: if (din == KEY_A) seq_d = SQ_W2;
        SQ_W2: if (din == KEY_B) seq_d = SQ_W3;
        SQ_W3: begin
          if (din == OPC_PGM)      seq_d = SQ_PDATA;
          else if (din == OPC_ERS) seq_d = SQ_W4;
        end
        SQ_PDATA: begin
          cmd_valid = 1'b1;
          cmd_kind  = CMD_PGM;
        end
        SQ_W4: if (din == KEY_A) seq_d = SQ_W5;
        SQ_W5: if (din == KEY_B) seq_d = SQ_W6;
        SQ_W6: begin
          if (din == OPC_CHIP) begin
            cmd_valid = 1'b1;
            cmd_kind  = CMD_CHIP_ERS;
          end else if (din == OPC_SECT) begin
            cmd_valid = 1'b1;
            cmd_kind  = CMD_SECT_ERS;
          end
        end
        default: seq_d = SQ_W1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_W1;
      we_q  <= 1'b1;
    end else begin
      seq_q <= seq_d;
      we_q  <= we_n;
    end
  end

endmodule

// File: rtl/fsg_op_ctrl.sv
module fsg_op_ctrl
  import flash_status_pkg::*;
#(
  parameter int                       ADDR_W       = 6,
  parameter int                       SECT_W       = 2,
  parameter logic [(1<<SECT_W)-1:0]   PROT_MASK    = 4'b0100,
  parameter int                       SE_WIN_CYC   = 64,
  parameter int                       PROT_PGM_CYC = 100,
  parameter int                       PROT_ERS_CYC = 5000,
  parameter int                       TIMEOUT_CYC  = 20000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  cmd_e                       cmd_kind,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [7:0]                 cmd_data,
  input  logic                       op_done,
  output op_state_e                  state,
  output logic                       op_start,
  output logic                       busy,
  output logic                       fail,
  output logic                       poll7,
  output logic                       is_erase,
  output logic                       pgm_commit,
  output logic [ADDR_W-1:0]          pgm_addr,
  output logic [7:0]                 pgm_data,
  output logic                       ers_commit,
  output logic [(1<<SECT_W)-1:0]     ers_mask,
  output logic                       tmo_hit
);

  localparam int NSECT = 1 << SECT_W;
  localparam int MAX_A = (SE_WIN_CYC > PROT_PGM_CYC) ? SE_WIN_CYC : PROT_PGM_CYC;
  localparam int MAX_B = (PROT_ERS_CYC > TIMEOUT_CYC) ? PROT_ERS_CYC : TIMEOUT_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [CNT_W-1:0] SE_LAST  = CNT_W'(SE_WIN_CYC - 1);
  localparam logic [CNT_W-1:0] PP_LAST  = CNT_W'(PROT_PGM_CYC - 1);
  localparam logic [CNT_W-1:0] PE_LAST  = CNT_W'(PROT_ERS_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYC - 1);

  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  function automatic logic [NSECT-1:0] sector_sel(input logic chip,
                                                  input logic [SECT_W-1:0] s);
    return chip ? {NSECT{1'b1}} : (NSECT'(1) << s);
  endfunction

  op_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lim_q;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [7:0]        tgt_data_q;
  logic [NSECT-1:0]  mask_q;
  logic              erase_q;

  logic [NSECT-1:0]  sel_eff;
  logic              tgt_prot;
  logic              run_phase;

  assign sel_eff   = sector_sel(cmd_kind == CMD_CHIP_ERS, sector_of(cmd_addr)) & ~PROT_MASK;
  assign tgt_prot  = PROT_MASK[sector_of(cmd_addr)];
  assign run_phase = (st_q == OP_PGM) || (st_q == OP_ERS);

  assign state      = st_q;
  assign op_start   = (st_q == OP_IDLE) && cmd_valid;
  assign busy       = (st_q != OP_IDLE) && (st_q != OP_FAIL);
  assign fail       = (st_q == OP_FAIL);
  assign is_erase   = erase_q;
  assign poll7      = f_poll_bit(erase_q, tgt_data_q[7]);
  assign pgm_commit = (st_q == OP_PGM) && op_done;
  assign ers_commit = (st_q == OP_ERS) && op_done;
  assign pgm_addr   = tgt_addr_q;
  assign pgm_data   = tgt_data_q;
  assign ers_mask   = mask_q;
  assign tmo_hit    = run_phase && !op_done && (cnt_q == TMO_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= OP_IDLE;
      cnt_q      <= '0;
      lim_q      <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      mask_q     <= '0;
      erase_q    <= 1'b0;
    end else begin
      case (st_q)
        OP_IDLE: begin
          if (cmd_valid) begin
            cnt_q      <= '0;
            tgt_addr_q <= cmd_addr;
            tgt_data_q <= cmd_data;
            if (cmd_kind == CMD_PGM) begin
              erase_q <= 1'b0;
              mask_q  <= '0;
              if (tgt_prot) begin
                st_q  <= OP_PROT;
                lim_q <= PP_LAST;
              end else begin
                st_q  <= OP_PGM;
              end
            end else begin
              erase_q <= 1'b1;
              mask_q  <= sel_eff;
              if (sel_eff == '0) begin
                st_q  <= OP_PROT;
                lim_q <= PE_LAST;
              end else if (cmd_kind == CMD_SECT_ERS) begin
                st_q  <= OP_SE_WIN;
              end else begin
                st_q  <= OP_ERS;
              end
            end
          end
        end
        OP_SE_WIN: begin
          if (cnt_q == SE_LAST) begin
            st_q  <= OP_ERS;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        OP_PROT: begin
          if (cnt_q == lim_q) st_q <= OP_IDLE;
          else                cnt_q <= cnt_q + 1'b1;
        end
        OP_PGM, OP_ERS: begin
          if (op_done)      st_q <= OP_IDLE;
          else if (tmo_hit) st_q <= OP_FAIL;
          else              cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= OP_FAIL;
      endcase
    end
  end

endmodule

// File: rtl/fsg_array.sv
module fsg_array #(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data,
  input  logic                   pgm_commit,
  input  logic [ADDR_W-1:0]      pgm_addr,
  input  logic [7:0]             pgm_data,
  input  logic                   ers_commit,
  input  logic [(1<<SECT_W)-1:0] ers_mask
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int SECT_SIZE = 1 << (ADDR_W - SECT_W);

  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam int SEC = i / SECT_SIZE;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= 8'hFF;
      end else if (ers_commit && ers_mask[SEC]) begin
        mem[i] <= 8'hFF;
      end else if (pgm_commit && (pgm_addr == ADDR_W'(i))) begin
        mem[i] <= mem[i] & pgm_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
  import flash_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       op_start,
  input  logic       busy,
  input  logic       fail,
  input  logic       poll7,
  input  logic [7:0] rd_data,
  output logic       rd_access,
  output logic [7:0] dout
);

  logic ce_q, oe_q, tgl_q;

  assign rd_access = (ce_q && !ce_n) || (oe_q && !oe_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b1;
      oe_q  <= 1'b1;
      tgl_q <= 1'b0;
    end else begin
      ce_q <= ce_n;
      oe_q <= oe_n;
      if (op_start)               tgl_q <= 1'b0;
      else if (busy && rd_access) tgl_q <= ~tgl_q;
    end
  end

  always_comb begin
    if (fail)      dout = f_status_byte(poll7, 1'b0, 1'b1);
    else if (busy) dout = f_status_byte(poll7, tgl_q, 1'b0);
    else           dout = rd_data;
  end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int                     ADDR_W       = 6,
  parameter int                     SECT_W       = 2,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK    = 4'b0100,
  parameter int                     SE_WIN_CYC   = 64,
  parameter int                     PROT_PGM_CYC = 100,
  parameter int                     PROT_ERS_CYC = 5000,
  parameter int                     TIMEOUT_CYC  = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              op_done,
  output logic [7:0]        dout
);

  localparam int NSECT = 1 << SECT_W;

  logic              cmd_valid;
  cmd_e              cmd_kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  logic              we_rise;
  op_state_e         op_state;
  logic              op_start, op_busy, op_fail, poll7, is_erase;
  logic              pgm_commit, ers_commit, tmo_hit, rd_access;
  logic [ADDR_W-1:0] pgm_addr;
  logic [7:0]        pgm_data;
  logic [NSECT-1:0]  ers_mask;
  logic [7:0]        rd_data;
  logic              ers_phase;

  assign ers_phase = op_busy && is_erase;

  fsg_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .enable(op_state == OP_IDLE), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .we_rise(we_rise)
  );

  fsg_op_ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROT_MASK(PROT_MASK),
    .SE_WIN_CYC(SE_WIN_CYC), .PROT_PGM_CYC(PROT_PGM_CYC),
    .PROT_ERS_CYC(PROT_ERS_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .op_done(op_done),
    .state(op_state), .op_start(op_start), .busy(op_busy), .fail(op_fail),
    .poll7(poll7), .is_erase(is_erase), .pgm_commit(pgm_commit),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data), .ers_commit(ers_commit),
    .ers_mask(ers_mask), .tmo_hit(tmo_hit)
  );

  fsg_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(rd_data),
    .pgm_commit(pgm_commit), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .ers_commit(ers_commit), .ers_mask(ers_mask)
  );

  fsg_status_mux u_mux (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .op_start(op_start),
    .busy(op_busy), .fail(op_fail), .poll7(poll7), .rd_data(rd_data),
    .rd_access(rd_access), .dout(dout)
  );

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] dout,
  input logic       op_busy,
  input logic       op_fail,
  input logic       op_start,
  input logic       rd_access,
  input logic       ers_phase,
  input logic       pgm_commit,
  input logic       ers_commit,
  input logic       tmo_hit,
  input logic       we_rise
);

  p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |-> (dout[5:0] == 6'd0));

  p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ers_phase |-> !dout[7]);

  p_toggle_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && rd_access && !op_start) |=> (!op_busy || (dout[6] != $past(dout[6]))));

  p_toggle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !rd_access && !op_start) |=> (!op_busy || $stable(dout[6])));

  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_fail |=> op_fail);

  p_fail_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_fail |-> (dout[6:0] == 7'b0100000));

  p_timeout_enters_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> op_fail);

  p_one_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_commit, ers_commit}));

  p_start_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> we_rise);

endmodule

bind flash_status_gen fsg_checker u_fsg_checker (
  .clk(clk), .rst_n(rst_n), .dout(dout), .op_busy(op_busy), .op_fail(op_fail),
  .op_start(op_start), .rd_access(rd_access), .ers_phase(ers_phase),
  .pgm_commit(pgm_commit), .ers_commit(ers_commit), .tmo_hit(tmo_hit),
  .we_rise(we_rise)
);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;

  localparam int SE_WIN  = 16;
  localparam int PR_PGM  = 20;
  localparam int PR_ERS  = 40;
  localparam int TMO     = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b1, op_done = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  int         n_run = 0, n_fail = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  flash_status_gen #(
    .ADDR_W(6), .SECT_W(2), .PROT_MASK(4'b0100), .SE_WIN_CYC(SE_WIN),
    .PROT_PGM_CYC(PR_PGM), .PROT_ERS_CYC(PR_ERS), .TIMEOUT_CYC(TMO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .op_done(op_done), .dout(dout)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; op_done = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); we_n = 1'b0; addr = a; din = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmd_pgm(input logic [5:0] a, input logic [7:0] d);
    wr(6'd0, 8'hAA); wr(6'd0, 8'h55); wr(6'd0, 8'hA0); wr(a, d);
  endtask

  task automatic cmd_ers(input logic [5:0] a, input logic chip);
    wr(6'd0, 8'hAA); wr(6'd0, 8'h55); wr(6'd0, 8'h80);
    wr(6'd0, 8'hAA); wr(6'd0, 8'h55); wr(a, chip ? 8'h10 : 8'h30);
  endtask

  // read access through output enable; sample after the access edge
  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; oe_n = 1'b0;
    @(negedge clk); v = dout; oe_n = 1'b1;
  endtask

  task automatic pulse_done;
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    do_reset();
    rd(6'd0, v);  chk("R1 reset byte 0", v, 8'hFF);
    rd(6'd63, v); chk("R1 reset byte 63", v, 8'hFF);
  endtask

  task automatic t_program_toggle;
    logic [7:0] v;
    cmd_pgm(6'd5, 8'h3C);
    rd(6'd5, v); chk("R3/R5 first read poll inverted, bit6 1", v, 8'hC0);
    rd(6'd5, v); chk("R5 second read bit6 0", v, 8'h80);
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); chk("R5 chip-enable fall toggles", dout, 8'hC0);
    ce_n = 1'b1;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); chk("R5 simultaneous falls count once", dout, 8'h80);
    oe_n = 1'b1;
    idle(2); chk("R5 no access holds bit6", dout, 8'h80);
    chk("R6 low bits zero while busy", dout & 8'h3F, 8'h00);
    pulse_done();
    rd(6'd5, v); chk("R3 true data after program", v, 8'h3C);
  endtask

  task automatic t_program_and;
    logic [7:0] v;
    cmd_pgm(6'd6, 8'hA5);
    rd(6'd6, v); chk("R3 poll for data bit7 1 reads 0", v, 8'h40);
    pulse_done();
    rd(6'd6, v); chk("R3 data 6 stored", v, 8'hA5);
    cmd_pgm(6'd5, 8'hF0);
    pulse_done();
    rd(6'd5, v); chk("R3 program ANDs into cell", v, 8'h30);
  endtask

  task automatic t_bad_sequence;
    logic [7:0] v;
    wr(6'd0, 8'hAA); wr(6'd0, 8'h55); wr(6'd0, 8'h12);
    wr(6'd7, 8'hA0); wr(6'd7, 8'h00);
    idle(2);
    rd(6'd7, v); chk("R2/R11 broken sequence leaves idle read", v, 8'hFF);
  endtask

  task automatic t_busy_ignores;
    logic [7:0] v;
    cmd_pgm(6'd20, 8'h11);
    cmd_pgm(6'd21, 8'h00);
    pulse_done();
    rd(6'd20, v); chk("R11 first program done", v, 8'h11);
    rd(6'd21, v); chk("R11 command while busy ignored", v, 8'hFF);
  endtask

  task automatic t_prot_program;
    logic [7:0] v;
    cmd_pgm(6'd40, 8'h00);
    rd(6'd40, v); chk("R8/R12 protected program busy", v, 8'hC0);
    pulse_done();
    rd(6'd40, v); chk("R8 done ignored in protected window", v, 8'h80);
    idle(PR_PGM + 5);
    rd(6'd40, v); chk("R8 protected cell unchanged", v, 8'hFF);
  endtask

  task automatic t_prot_erase;
    logic [7:0] v;
    cmd_ers(6'd40, 1'b0);
    rd(6'd40, v); chk("R9 all-protected erase busy", v, 8'h40);
    idle(PR_ERS + 5);
    rd(6'd20, v); chk("R9 back to read mode, data kept", v, 8'h11);
  endtask

  task automatic t_sector_erase;
    logic [7:0] v;
    cmd_ers(6'd5, 1'b0);
    rd(6'd5, v); chk("R7 window status", v, 8'h40);
    pulse_done();
    rd(6'd5, v); chk("R7 done ignored in window", v, 8'h00);
    idle(SE_WIN + 4);
    rd(6'd5, v); chk("R4 erase busy bit7 0", v, 8'h40);
    pulse_done();
    rd(6'd5, v);  chk("R4 erased byte reads FF", v, 8'hFF);
    rd(6'd6, v);  chk("R4 same sector erased", v, 8'hFF);
    rd(6'd20, v); chk("R12 other sector kept", v, 8'h11);
  endtask

  task automatic t_chip_erase;
    logic [7:0] v;
    cmd_ers(6'd0, 1'b1);
    rd(6'd0, v); chk("R4 chip erase busy", v, 8'h40);
    pulse_done();
    rd(6'd20, v); chk("R9 chip erase clears unprotected", v, 8'hFF);
  endtask

  task automatic t_timeout;
    logic [7:0] v;
    cmd_pgm(6'd10, 8'h0F);
    idle(TMO - 60);
    rd(6'd10, v); chk("R10 before limit no timeout bit", v & 8'hA0, 8'h80);
    idle(80);
    rd(6'd10, v); chk("R10 timeout status", v, 8'hA0);
    rd(6'd10, v); chk("R10 no toggle after fail", v, 8'hA0);
    pulse_done();
    cmd_ers(6'd0, 1'b1);
    rd(6'd10, v); chk("R10 sticky after done and command", v, 8'hA0);
    do_reset();
    rd(6'd10, v); chk("R10/R1 reset clears failure", v, 8'hFF);
  endtask

  initial begin
    t_reset();
    t_program_toggle();
    t_program_and();
    t_bad_sequence();
    t_busy_ignores();
    t_prot_program();
    t_prot_erase();
    t_sector_erase();
    t_chip_erase();
    t_timeout();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule